// File: doc/BRIEF.md
# Hub Master Link Controller

This block sits behind an upstream slave-side bus and fans it out to up to eight downstream links. The upstream side issues one 32-bit access at a time. The block answers it from an internal control register block, forwards it to one link's request/response port, or refuses it with an error response. The register block holds the link enables, mode, delay and error-control settings. It also holds the captured error address and error status, and it accepts port-reset and bridge-reset commands. The physical serial link, its CRC and any logic behind a link sit outside this block.

Each link owns a 512 KiB window. The window for link n starts at 0x80000 + n*0x80000, and the registers occupy the lowest window. Software enables links by writing ones to a set register and disables them by writing ones to a clear register. In both registers link 0 is bit 31. A freshly enabled link refuses traffic for a configurable setup time, counted in clock cycles. A special word written at offset 4 of a ready link's window becomes a break pulse on that link and is not forwarded as data.

Top module: `hubm_link_ctrl`

## Requirements
- R1: After reset every output is 0, and the mode, enable (0x10), error status (0x1D0) and error address (0x70) registers read 0. The version register (0x74) reads the VERSION parameter.
- R2: A register access gets a response one cycle after it is sampled, and a write response carries data 0. Mode (0x0) stores only bits 31, 30, 28, 27:8 and 4, which is mask 0xDFFFFF10. Delay (0x4) stores all 32 bits. Error control (0x2E0) stores only bits 15 and 14. Writes to 0x70 and 0x74 leave them unchanged.
- R3: A write to 0x18 enables link n for each set bit 31-n. Offset 0x10 reads the enables in the same MSB-first layout, and bits for links at or above N_LINKS read 0.
- R4: A write to 0x20 disables link n for each set bit 31-n. Later accesses to that link's window are refused.
- R5: A read of 0x18 returns plug_det[n] at bit 31-n.
- R6: An accepted data access to address 0x80000*(n+1)+off produces a one-cycle lnk_req pulse on bit n only. The pulse carries lnk_addr = off (19 bits), lnk_we and lnk_wdata.
- R7: The upstream response, with the link's data and error flag, appears one cycle after the edge at which the selected link raises lnk_rsp_valid. No upstream response is given while lnk_req is high.
- R8: A write of 0xC0DE0000 to offset 4 of a ready link gives a one-cycle lnk_break pulse on that link and an error-free response in the same cycle, with no lnk_req. Other values at offset 4, and the break word at other offsets, are forwarded as data.
- R9: After a set-enable write sampled at edge E for a link that was disabled, accesses to that link sampled at edges up to E+SETUP_CYC are refused. From edge E+SETUP_CYC+1 they are accepted. Setting a link that is already enabled does not restart its setup.
- R10: An access to a disabled link, to a link still in setup, or above the last link is refused. A refused access gets an error response and no lnk_req. Its full address is stored at 0x70, and error status bit 31 is set.
- R11: A write to 0xD0 acts on each set bit. Bit 29 clears the enables, the error status and the error address. Bit 28 clears the enables and pulses lnk_rst on all links in the response cycle. Bit 27 clears mode, delay and error control. Bit 26 clears error status bit 30.
- R12: A write to 0x1D0 with bit 31 set clears the error status and the error address. With bit 30 set it clears the error status only. A read of 0x1D0 returns the error status in bits 31 (refused access) and 30 (link error).
- R13: mchk equals error-control bit 15 AND error status bit 31.
- R14: A link response with lnk_rsp_err set is returned upstream with up_rsp_err set and sets error status bit 30. It does not change the error address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Upstream access strobe, one cycle, only while no access is open |
| up_we | input | 1 | Upstream write enable |
| up_addr | input | ADDR_W | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_rsp_valid | output | 1 | Upstream response strobe |
| up_rsp_err | output | 1 | Upstream response error flag |
| up_rdata | output | 32 | Upstream response data |
| plug_det | input | N_LINKS | Link presence, bit n for link n |
| lnk_req | output | N_LINKS | One-hot request pulse to a link |
| lnk_we | output | 1 | Link request write enable |
| lnk_addr | output | 19 | Offset within the link window |
| lnk_wdata | output | 32 | Link request write data |
| lnk_rsp_valid | input | N_LINKS | Link response strobe, bit n for link n |
| lnk_rsp_err | input | N_LINKS | Link response error flag |
| lnk_rsp_data | input | 32*N_LINKS | Link response data, link n in bits 32n+31:32n |
| lnk_break | output | N_LINKS | One-cycle break pulse to a link |
| lnk_rst | output | N_LINKS | One-cycle link controller reset pulse |
| mchk | output | 1 | Machine-check indication |

## Verification
Register, break and refused accesses answer at the first falling edge after the rising edge that samples up_req. The bench checks the response fields, lnk_break and lnk_rst there, and at no earlier edge. A forwarded access shows lnk_req at that same falling edge. The bench then holds off the link response for a chosen number of cycles and expects nothing upstream until the falling edge after the edge that sees lnk_rsp_valid. The setup window is predicted from the edge count recorded after each sampling edge, so the refused-to-accepted change is checked at the exact edge SETUP_CYC+1 after the enabling write.

// File: rtl/hubm_pkg.sv
`timescale 1ns/1ps
package hubm_pkg;
   localparam int WIN_BITS = 19;

   localparam logic [WIN_BITS-1:0] OFS_MODE  = 19'h00000;
   localparam logic [WIN_BITS-1:0] OFS_DLY   = 19'h00004;
   localparam logic [WIN_BITS-1:0] OFS_EN    = 19'h00010;
   localparam logic [WIN_BITS-1:0] OFS_SET   = 19'h00018;
   localparam logic [WIN_BITS-1:0] OFS_CLR   = 19'h00020;
   localparam logic [WIN_BITS-1:0] OFS_EADDR = 19'h00070;
   localparam logic [WIN_BITS-1:0] OFS_VER   = 19'h00074;
   localparam logic [WIN_BITS-1:0] OFS_PRST  = 19'h000D0;
   localparam logic [WIN_BITS-1:0] OFS_BRG   = 19'h001D0;
   localparam logic [WIN_BITS-1:0] OFS_ECTL  = 19'h002E0;

   localparam logic [WIN_BITS-1:0] BREAK_OFS  = 19'h00004;
   localparam logic [31:0]         BREAK_WORD = 32'hC0DE_0000;

   localparam logic [31:0] MODE_WMASK = 32'hDFFF_FF10;
   localparam logic [31:0] ECTL_WMASK = 32'h0000_C000;

   // port reset command bits
   localparam int PR_ALL_MASTER = 29;
   localparam int PR_ALL_LINK   = 28;
   localparam int PR_REGS       = 27;
   localparam int PR_LERR       = 26;
   // bridge command bits
   localparam int BR_GEN = 31;
   localparam int BR_ERR = 30;
   // error control
   localparam int EC_MCHK = 15;

   typedef enum logic {ST_IDLE, ST_WAIT} seq_state_t;
endpackage

// File: rtl/hubm_decode.sv
`timescale 1ns/1ps
module hubm_decode
   import hubm_pkg::*;
#(
   parameter int ADDR_W  = 23,
   parameter int N_LINKS = 8,
   parameter int LIDX_W  = 3
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic                is_reg,
   output logic                is_link,
   output logic [LIDX_W-1:0]   link_idx,
   output logic [WIN_BITS-1:0] win_off
);
   localparam int RGN_W = ADDR_W - WIN_BITS;

   logic [RGN_W-1:0] rgn;
   logic [RGN_W-1:0] lsel;

   if (RGN_W < LIDX_W || (2 ** RGN_W) <= N_LINKS) begin : g_bad_rgn
      $error("hubm_decode: ADDR_W too small to hold all link windows");
   end

   assign rgn      = addr[ADDR_W-1:WIN_BITS];
   assign lsel     = rgn - RGN_W'(1);
   assign is_reg   = (rgn == '0);
   assign is_link  = !is_reg && (lsel < RGN_W'(N_LINKS));
   assign link_idx = lsel[LIDX_W-1:0];
   assign win_off  = addr[WIN_BITS-1:0];
endmodule

// File: rtl/hubm_setup_timer.sv
`timescale 1ns/1ps
module hubm_setup_timer #(
   parameter int SETUP_CYC = 16,
   parameter int CNT_W     = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic en,
   output logic ready
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= CNT_W'(SETUP_CYC);
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign ready = en && (cnt == '0);
endmodule

// File: rtl/hubm_regs.sv
`timescale 1ns/1ps
module hubm_regs
   import hubm_pkg::*;
#(
   parameter int          N_LINKS = 8,
   parameter logic [31:0] VERSION = 32'h0001_0008
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [WIN_BITS-1:0] off,
   input  logic [31:0]         wdata,
   input  logic                acc_err,
   input  logic [31:0]         acc_addr,
   input  logic                lnk_err,
   input  logic [N_LINKS-1:0]  plug,
   output logic [N_LINKS-1:0]  en,
   output logic [N_LINKS-1:0]  set_start,
   output logic [N_LINKS-1:0]  lnk_rst,
   output logic                mchk,
   output logic [31:0]         rdata
);
   logic [31:0] mode_q, dly_q, ectl_q, eaddr_q;
   logic [1:0]  errst_q;            // [1] refused access, [0] link error
   logic [N_LINKS-1:0] en_q, set_bits, clr_bits;
   logic [31:0] en_map, plug_map;
   logic wr_mode, wr_dly, wr_set, wr_clr, wr_prst, wr_brg, wr_ectl;

   assign wr_mode = wr && (off == OFS_MODE);
   assign wr_dly  = wr && (off == OFS_DLY);
   assign wr_set  = wr && (off == OFS_SET);
   assign wr_clr  = wr && (off == OFS_CLR);
   assign wr_prst = wr && (off == OFS_PRST);
   assign wr_brg  = wr && (off == OFS_BRG);
   assign wr_ectl = wr && (off == OFS_ECTL);

   for (genvar g = 0; g < N_LINKS; g++) begin : g_bit
      assign set_bits[g]  = wr_set && wdata[31-g];
      assign clr_bits[g]  = wr_clr && wdata[31-g];
      assign set_start[g] = set_bits[g] && !en_q[g];
   end

   always_comb begin
      en_map   = '0;
      plug_map = '0;
      for (int n = 0; n < N_LINKS; n++) begin
         en_map[31-n]   = en_q[n];
         plug_map[31-n] = plug[n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         dly_q   <= '0;
         ectl_q  <= '0;
         eaddr_q <= '0;
         errst_q <= '0;
         en_q    <= '0;
         lnk_rst <= '0;
      end else begin
         lnk_rst <= {N_LINKS{wr_prst && wdata[PR_ALL_LINK]}};
         if (wr_mode) mode_q <= wdata & MODE_WMASK;
         if (wr_dly)  dly_q  <= wdata;
         if (wr_ectl) ectl_q <= wdata & ECTL_WMASK;
         if (wr_prst && wdata[PR_REGS]) begin
            mode_q <= '0;
            dly_q  <= '0;
            ectl_q <= '0;
         end
         if (wr_prst && (wdata[PR_ALL_MASTER] || wdata[PR_ALL_LINK]))
            en_q <= '0;
         else
            en_q <= (en_q | set_bits) & ~clr_bits;
         if (wr_prst && wdata[PR_ALL_MASTER]) begin
            errst_q <= '0;
            eaddr_q <= '0;
         end
         if (wr_prst && wdata[PR_LERR]) errst_q[0] <= 1'b0;
         if (wr_brg && wdata[BR_GEN]) begin
            errst_q <= '0;
            eaddr_q <= '0;
         end else if (wr_brg && wdata[BR_ERR]) begin
            errst_q <= '0;
         end
         if (acc_err) begin
            errst_q[1] <= 1'b1;
            eaddr_q    <= acc_addr;
         end
         if (lnk_err) errst_q[0] <= 1'b1;
      end
   end

   always_comb begin
      case (off)
         OFS_MODE:  rdata = mode_q;
         OFS_DLY:   rdata = dly_q;
         OFS_EN:    rdata = en_map;
         OFS_SET:   rdata = plug_map;
         OFS_EADDR: rdata = eaddr_q;
         OFS_VER:   rdata = VERSION;
         OFS_BRG:   rdata = {errst_q, 30'b0};
         OFS_ECTL:  rdata = ectl_q;
         default:   rdata = '0;
      endcase
   end

   assign en   = en_q;
   assign mchk = ectl_q[EC_MCHK] && errst_q[1];
endmodule

// File: rtl/hubm_link_ctrl.sv
`timescale 1ns/1ps
module hubm_link_ctrl
   import hubm_pkg::*;
#(
   parameter int          N_LINKS   = 8,
   parameter int          ADDR_W    = 23,
   parameter int          SETUP_CYC = 500000,
   parameter logic [31:0] VERSION   = 32'h0001_0008
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   up_req,
   input  logic                   up_we,
   input  logic [ADDR_W-1:0]      up_addr,
   input  logic [31:0]            up_wdata,
   output logic                   up_rsp_valid,
   output logic                   up_rsp_err,
   output logic [31:0]            up_rdata,
   input  logic [N_LINKS-1:0]     plug_det,
   output logic [N_LINKS-1:0]     lnk_req,
   output logic                   lnk_we,
   output logic [WIN_BITS-1:0]    lnk_addr,
   output logic [31:0]            lnk_wdata,
   input  logic [N_LINKS-1:0]     lnk_rsp_valid,
   input  logic [N_LINKS-1:0]     lnk_rsp_err,
   input  logic [32*N_LINKS-1:0]  lnk_rsp_data,
   output logic [N_LINKS-1:0]     lnk_break,
   output logic [N_LINKS-1:0]     lnk_rst,
   output logic                   mchk
);
   localparam int LIDX_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;
   localparam int CNT_W  = (SETUP_CYC > 0) ? $clog2(SETUP_CYC + 1) : 1;

   if (N_LINKS < 1 || N_LINKS > 8) begin : g_bad_links
      $error("hubm_link_ctrl: N_LINKS must be 1..8");
   end
   if (ADDR_W > 32 || ADDR_W <= WIN_BITS) begin : g_bad_addr
      $error("hubm_link_ctrl: ADDR_W must be 20..32");
   end
   if (SETUP_CYC < 0) begin : g_bad_setup
      $error("hubm_link_ctrl: SETUP_CYC must not be negative");
   end

   logic                dec_reg, dec_link;
   logic [LIDX_W-1:0]   dec_idx, wait_idx;
   logic [WIN_BITS-1:0] dec_off;
   logic [N_LINKS-1:0]  en, set_start, ready;
   logic [31:0]         reg_rdata, sel_data;
   logic                go, reg_wr, link_ok, is_brk, acc_err, lnk_err, rsp_hit;
   seq_state_t          st;

   hubm_decode #(.ADDR_W(ADDR_W), .N_LINKS(N_LINKS), .LIDX_W(LIDX_W)) u_dec (
      .addr(up_addr), .is_reg(dec_reg), .is_link(dec_link),
      .link_idx(dec_idx), .win_off(dec_off)
   );

   for (genvar g = 0; g < N_LINKS; g++) begin : g_lnk
      if (SETUP_CYC == 0) begin : g_notimer
         assign ready[g] = en[g];
      end else begin : g_timer
         hubm_setup_timer #(.SETUP_CYC(SETUP_CYC), .CNT_W(CNT_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .start(set_start[g]),
            .en(en[g]), .ready(ready[g])
         );
      end
   end

   assign go       = up_req && (st == ST_IDLE);
   assign reg_wr   = go && dec_reg && up_we;
   assign link_ok  = dec_link && ready[dec_idx];
   assign is_brk   = up_we && (dec_off == BREAK_OFS) && (up_wdata == BREAK_WORD);
   assign acc_err  = go && !dec_reg && !link_ok;
   assign rsp_hit  = (st == ST_WAIT) && lnk_rsp_valid[wait_idx];
   assign lnk_err  = rsp_hit && lnk_rsp_err[wait_idx];
   assign sel_data = lnk_rsp_data[32*wait_idx +: 32];

   hubm_regs #(.N_LINKS(N_LINKS), .VERSION(VERSION)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .off(dec_off), .wdata(up_wdata),
      .acc_err(acc_err), .acc_addr(32'(up_addr)), .lnk_err(lnk_err),
      .plug(plug_det), .en(en), .set_start(set_start), .lnk_rst(lnk_rst),
      .mchk(mchk), .rdata(reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         wait_idx     <= '0;
         up_rsp_valid <= 1'b0;
         up_rsp_err   <= 1'b0;
         up_rdata     <= '0;
         lnk_req      <= '0;
         lnk_break    <= '0;
         lnk_we       <= 1'b0;
         lnk_addr     <= '0;
         lnk_wdata    <= '0;
      end else begin
         up_rsp_valid <= 1'b0;
         up_rsp_err   <= 1'b0;
         lnk_req      <= '0;
         lnk_break    <= '0;
         if (go) begin
            if (dec_reg) begin
               up_rsp_valid <= 1'b1;
               up_rdata     <= up_we ? 32'h0 : reg_rdata;
            end else if (link_ok && is_brk) begin
               lnk_break[dec_idx] <= 1'b1;
               up_rsp_valid       <= 1'b1;
               up_rdata           <= '0;
            end else if (link_ok) begin
               lnk_req[dec_idx] <= 1'b1;
               lnk_we           <= up_we;
               lnk_addr         <= dec_off;
               lnk_wdata        <= up_wdata;
               wait_idx         <= dec_idx;
               st               <= ST_WAIT;
            end else begin
               up_rsp_valid <= 1'b1;
               up_rsp_err   <= 1'b1;
               up_rdata     <= '0;
            end
         end else if (rsp_hit) begin
            up_rsp_valid <= 1'b1;
            up_rsp_err   <= lnk_rsp_err[wait_idx];
            up_rdata     <= sel_data;
            st           <= ST_IDLE;
         end
      end
   end
endmodule

// File: rtl/hubm_link_ctrl_chk.sv
`timescale 1ns/1ps
module hubm_link_ctrl_chk #(
   parameter int N_LINKS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               up_rsp_valid,
   input logic               up_rsp_err,
   input logic [N_LINKS-1:0] lnk_req,
   input logic [N_LINKS-1:0] lnk_break,
   input logic [N_LINKS-1:0] lnk_rst
);
   p_req_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lnk_req));

   p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|lnk_req) |=> !(|lnk_req));

   p_req_no_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|lnk_req) |-> !up_rsp_valid);

   p_break_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lnk_break));

   p_break_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|lnk_break) |-> !(|lnk_req));

   p_break_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|lnk_break) |-> (up_rsp_valid && !up_rsp_err));

   p_lrst_with_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|lnk_rst) |-> (up_rsp_valid && !up_rsp_err));
endmodule

bind hubm_link_ctrl hubm_link_ctrl_chk #(.N_LINKS(N_LINKS)) u_chk (.*);

// File: tb/hubm_link_ctrl_tb_top.sv
`timescale 1ns/1ps
module hubm_link_ctrl_tb_top;
   localparam int N  = 8;
   localparam int AW = 23;
   localparam int S  = 12;
   localparam logic [31:0] VER = 32'h0005_A0B1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            up_req = 1'b0, up_we = 1'b0;
   logic [AW-1:0]   up_addr = '0;
   logic [31:0]     up_wdata = '0;
   logic            up_rsp_valid, up_rsp_err;
   logic [31:0]     up_rdata;
   logic [N-1:0]    plug_det = '0;
   logic [N-1:0]    lnk_req, lnk_break, lnk_rst;
   logic            lnk_we, mchk;
   logic [18:0]     lnk_addr;
   logic [31:0]     lnk_wdata;
   logic [N-1:0]    lnk_rsp_valid = '0, lnk_rsp_err = '0;
   logic [32*N-1:0] lnk_rsp_data = '0;

   hubm_link_ctrl #(.N_LINKS(N), .ADDR_W(AW), .SETUP_CYC(S), .VERSION(VER)) dut_i (
      .clk, .rst_n, .up_req, .up_we, .up_addr, .up_wdata, .up_rsp_valid,
      .up_rsp_err, .up_rdata, .plug_det, .lnk_req, .lnk_we, .lnk_addr,
      .lnk_wdata, .lnk_rsp_valid, .lnk_rsp_err, .lnk_rsp_data, .lnk_break,
      .lnk_rst, .mchk
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] m_mode = 0, m_dly = 0, m_ectl = 0, m_eaddr = 0;
   bit m_es_acc = 0, m_es_lnk = 0;
   bit m_en [N];
   int m_set_edge [N];

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_en_map();
      logic [31:0] v = '0;
      for (int n = 0; n < N; n++) v[31-n] = m_en[n];
      return v;
   endfunction

   function automatic logic [31:0] m_read(logic [18:0] off);
      logic [31:0] p = '0;
      for (int n = 0; n < N; n++) p[31-n] = plug_det[n];
      case (off)
         19'h00: return m_mode;
         19'h04: return m_dly;
         19'h10: return m_en_map();
         19'h18: return p;
         19'h70: return m_eaddr;
         19'h74: return VER;
         19'h1D0: return {m_es_acc, m_es_lnk, 30'b0};
         19'h2E0: return m_ectl;
         default: return 32'h0;
      endcase
   endfunction

   task automatic m_write(logic [18:0] off, logic [31:0] wd, int e);
      case (off)
         19'h00: m_mode = wd & 32'hDFFF_FF10;
         19'h04: m_dly = wd;
         19'h18: for (int n = 0; n < N; n++)
                    if (wd[31-n] && !m_en[n]) begin m_en[n] = 1; m_set_edge[n] = e; end
         19'h20: for (int n = 0; n < N; n++) if (wd[31-n]) m_en[n] = 0;
         19'h D0: begin
            if (wd[27]) begin m_mode = 0; m_dly = 0; m_ectl = 0; end
            if (wd[29] || wd[28]) for (int n = 0; n < N; n++) m_en[n] = 0;
            if (wd[29]) begin m_es_acc = 0; m_es_lnk = 0; m_eaddr = 0; end
            if (wd[26]) m_es_lnk = 0;
         end
         19'h1D0: begin
            if (wd[31]) begin m_es_acc = 0; m_es_lnk = 0; m_eaddr = 0; end
            else if (wd[30]) begin m_es_acc = 0; m_es_lnk = 0; end
         end
         19'h2E0: m_ectl = wd & 32'h0000_C000;
         default: ;
      endcase
   endtask

   // one upstream access; all expectations come from the model
   task automatic acc(string req, bit we, logic [31:0] addr, logic [31:0] wd,
                      int lat = 0, bit lerr = 0);
      int e, rgn, n;
      logic [18:0] off;
      logic [31:0] exp_rd, ldat;
      logic [N-1:0] exp_rst;
      @(negedge clk);
      up_req = 1; up_we = we; up_addr = addr[AW-1:0]; up_wdata = wd;
      @(posedge clk); #1;
      e = cyc; up_req = 0;
      rgn = int'(addr[22:19]); off = addr[18:0]; n = rgn - 1;
      if (rgn == 0) begin
         exp_rd  = we ? 32'h0 : m_read(off);
         exp_rst = (we && off == 19'hD0 && wd[28]) ? '1 : '0;
         if (we) m_write(off, wd, e);
         @(negedge clk);
         chk(req, "reg rsp_valid", 32'(up_rsp_valid), 1);
         chk(req, "reg rsp_err", 32'(up_rsp_err), 0);
         chk(req, "reg rdata", up_rdata, exp_rd);
         chk("R11", "lnk_rst", 32'(lnk_rst), 32'(exp_rst));
         chk(req, "reg no lnk_req", 32'(lnk_req), 0);
      end else if (n >= N || !m_en[n] || e < m_set_edge[n] + S + 1) begin
         m_es_acc = 1; m_eaddr = addr & ((32'h1 << AW) - 1);
         @(negedge clk);
         chk(req, "refused rsp_valid", 32'(up_rsp_valid), 1);
         chk(req, "refused rsp_err", 32'(up_rsp_err), 1);
         chk(req, "refused no lnk_req", 32'(lnk_req), 0);
      end else if (we && off == 19'h4 && wd == 32'hC0DE_0000) begin
         @(negedge clk);
         chk(req, "break pulse", 32'(lnk_break), 32'(1) << n);
         chk(req, "break rsp_valid", 32'(up_rsp_valid), 1);
         chk(req, "break rsp_err", 32'(up_rsp_err), 0);
         chk(req, "break no lnk_req", 32'(lnk_req), 0);
      end else begin
         @(negedge clk);
         chk("R6", "lnk_req", 32'(lnk_req), 32'(1) << n);
         chk("R6", "lnk_addr", 32'(lnk_addr), 32'(off));
         chk("R6", "lnk_we", 32'(lnk_we), 32'(we));
         if (we) chk("R6", "lnk_wdata", lnk_wdata, wd);
         chk("R8", "no break on data", 32'(lnk_break), 0);
         chk("R7", "no early rsp", 32'(up_rsp_valid), 0);
         for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk("R7", "no rsp while waiting", 32'(up_rsp_valid), 0);
         end
         ldat = 32'hA500_0000 | (32'(n) << 16) | 32'(off[15:0]);
         lnk_rsp_valid[n] = 1; lnk_rsp_err[n] = lerr;
         lnk_rsp_data[32*n +: 32] = ldat;
         @(negedge clk);
         lnk_rsp_valid = '0; lnk_rsp_err = '0;
         if (lerr) m_es_lnk = 1;
         chk("R7", "link rsp_valid", 32'(up_rsp_valid), 1);
         chk(lerr ? "R14" : "R7", "link rsp_err", 32'(up_rsp_err), 32'(lerr));
         chk("R7", "link rdata", up_rdata, ldat);
      end
      chk("R13", "mchk", 32'(mchk), 32'(m_ectl[15] & m_es_acc));
   endtask

   function automatic logic [31:0] lw(int n, logic [18:0] off);
      return 32'h80000 * (n + 1) + 32'(off);
   endfunction

   initial begin
      for (int n = 0; n < N; n++) begin m_en[n] = 0; m_set_edge[n] = 0; end
      repeat (3) @(negedge clk);
      chk("R1", "rsp_valid in reset", 32'(up_rsp_valid), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "lnk_req", 32'(lnk_req), 0);
      chk("R1", "lnk_break", 32'(lnk_break), 0);
      chk("R1", "lnk_rst", 32'(lnk_rst), 0);
      chk("R1", "mchk", 32'(mchk), 0);
      acc("R1", 0, 32'h00, 0);
      acc("R1", 0, 32'h10, 0);
      acc("R1", 0, 32'h1D0, 0);
      acc("R1", 0, 32'h70, 0);
      acc("R1", 0, 32'h74, 0);
      // R2 register storage and read-only locations
      acc("R2", 1, 32'h00, 32'hFFFF_FFFF);
      acc("R2", 0, 32'h00, 0);
      acc("R2", 1, 32'h04, 32'h1234_5678);
      acc("R2", 0, 32'h04, 0);
      acc("R2", 1, 32'h2E0, 32'hFFFF_FFFF);
      acc("R2", 0, 32'h2E0, 0);
      acc("R2", 1, 32'h70, 32'hDEAD_BEEF);
      acc("R2", 1, 32'h74, 32'hDEAD_BEEF);
      acc("R2", 0, 32'h70, 0);
      acc("R2", 0, 32'h74, 0);
      // R5 plug detect
      plug_det = 8'b1010_0101;
      acc("R5", 0, 32'h18, 0);
      // R10 disabled link refused, R13 machine check follows
      acc("R10", 0, lw(0, 19'h100), 0);
      acc("R10", 0, 32'h70, 0);
      acc("R12", 0, 32'h1D0, 0);
      acc("R12", 1, 32'h1D0, 32'h4000_0000);
      acc("R12", 0, 32'h70, 0);
      acc("R12", 0, 32'h1D0, 0);
      // R3 enable links 0 and 7, R9 setup window boundary
      acc("R3", 1, 32'h18, 32'h8100_0000);
      acc("R3", 0, 32'h10, 0);
      for (int k = 0; k < 10; k++) acc("R9", 0, lw(0, 19'h40), 0);
      acc("R9", 1, 32'h18, 32'h8000_0000);
      acc("R6", 0, lw(0, 19'h7FFFC), 0, 0);
      acc("R7", 0, lw(0, 19'h00008), 0, 3);
      acc("R6", 1, lw(7, 19'h00010), 32'hCAFE_F00D, 1);
      // R8 break and near misses
      acc("R8", 1, lw(7, 19'h4), 32'hC0DE_0000);
      acc("R8", 1, lw(0, 19'h4), 32'hC0DE_0000);
      acc("R8", 1, lw(7, 19'h8), 32'hC0DE_0000);
      acc("R8", 1, lw(7, 19'h4), 32'hC0DE_0001);
      acc("R8", 0, lw(7, 19'h4), 0);
      // R10 beyond last link
      acc("R10", 0, 32'h80000 * 9 + 32'h20, 0);
      acc("R10", 1, 32'h80000 * 15 + 32'h4, 32'hC0DE_0000);
      acc("R10", 0, 32'h70, 0);
      // R14 link error, R11 bit 26 clears it
      acc("R14", 0, lw(7, 19'h30), 0, 2, 1);
      acc("R14", 0, 32'h1D0, 0);
      acc("R14", 0, 32'h70, 0);
      acc("R11", 1, 32'hD0, 32'h0400_0000);
      acc("R11", 0, 32'h1D0, 0);
      // R4 clear enable
      acc("R4", 1, 32'h20, 32'h8000_0000);
      acc("R4", 0, 32'h10, 0);
      acc("R4", 0, lw(0, 19'h40), 0);
      acc("R4", 0, lw(7, 19'h40), 0);
      // R11 remaining port reset bits
      acc("R11", 1, 32'hD0, 32'h1000_0000);
      acc("R11", 0, 32'h10, 0);
      acc("R11", 0, 32'h00, 0);
      acc("R11", 1, 32'hD0, 32'h0800_0000);
      acc("R11", 0, 32'h00, 0);
      acc("R11", 0, 32'h2E0, 0);
      acc("R11", 0, 32'h04, 0);
      acc("R11", 1, 32'h2E0, 32'h0000_8000);
      acc("R13", 0, lw(3, 19'h0), 0);
      acc("R11", 1, 32'h18, 32'h1000_0000);
      acc("R11", 1, 32'hD0, 32'h2000_0000);
      acc("R11", 0, 32'h10, 0);
      acc("R11", 0, 32'h70, 0);
      acc("R11", 0, 32'h1D0, 0);
      // R12 general bridge reset
      acc("R12", 0, lw(2, 19'h44), 0);
      acc("R12", 1, 32'h1D0, 32'h8000_0000);
      acc("R12", 0, 32'h70, 0);
      acc("R12", 0, 32'h1D0, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule